// File: doc/BRIEF.md
# Display-Bridge I2C Register Target

This block is the control-register front end of a video transmitter, reached over a two-wire I2C bus. It samples SCL and SDA with the system clock, detects START and STOP conditions, answers a parameterised 7-bit device address and pulls SDA low through an open-drain enable. A write transaction uses its first data byte to load a register pointer. Every later data byte, written or read, moves that pointer on by one.

Only three offsets have content. The system-control register carries a bus-request/grant handshake for the monitor-data channel. The identification register returns a fixed value. The interrupt-status register always reports an attached sink with no pending hot-plug event. A registered `ddc_mode` output tells an external multiplexer when to route the bus to the monitor's data memory. All other offsets read as zero, and writes to them are acknowledged and dropped.

Top module: `vtx_ctrl_i2c`

## Requirements
- R1: The target acknowledges only its own 7-bit address (default 0x39, sent as the upper seven bits of the address byte, with bit 0 = 1 for a read). A foreign address gets no acknowledge, and SDA is never pulled low until the next START.
- R2: In a write transaction, the first data byte after the address loads the register pointer and is not written as register data.
- R3: The pointer increases by one after every data byte written or read. It keeps its value across a repeated START and across STOP, so a new read continues where the last access left off.
- R4: Writing the system-control offset 0x1A with bit 2 set records a monitor-data bus request. If bit 1 is also set in the same byte, the write arms monitor-data mode.
- R5: Writing offset 0x1A with bit 2 clear clears both the request and monitor-data mode.
- R6: Reading offset 0x1A returns 0x06 while a request is recorded, and 0x00 otherwise.
- R7: Reading offset 0x1B returns 0xB0.
- R8: Reading offset 0x3D returns 0x04. Every other offset reads 0x00. Writes to 0x1B, 0x3D and unused offsets change nothing that can be read back.
- R9: `ddc_mode` changes only on the STOP that ends the write which armed or cleared monitor-data mode. It holds its value during the rest of that transaction.
- R10: After reset, `ddc_mode` is 0, SDA is released and the pointer is 0x00. A read issued with no pointer write therefore starts at offset 0x00.
- R11: When the master NACKs a read byte, the target releases SDA and drives nothing more until a new START.
- R12: Every byte written to the target is acknowledged. The SDA drive changes only while SCL is low, except when a START or STOP releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | I2C clock line as seen on the pad |
| sda_i | input | 1 | I2C data line as seen on the pad |
| sda_oe | output | 1 | Drives SDA low while 1 (open-drain) |
| ddc_mode | output | 1 | Routes the bus to the monitor-data memory while 1 |

## Verification
Two events can coincide on the same SCL edge. One is the data-byte write that changes the handshake state. The other is the pointer step, which decides which register the next byte lands in. Handshake values are written in the middle of a multi-byte burst, and a read-back from the start of the burst then shows whether both updates took effect. Separately, the update of the mode flag sits apart from the byte that armed it, because it waits for the STOP. A behavioural model in the bench compares `ddc_mode` on every clock, with comparison paused only during the STOP window. Explicit checks sample the flag between the last data byte and the STOP.

// File: rtl/vtx_ctrl_i2c.sv
module vtx_ctrl_i2c #(
  parameter logic [6:0] DEV_ADDR    = 7'h39,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] SYSCTL_OFS  = 8'h1A,
  parameter logic [7:0] ID_OFS      = 8'h1B,
  parameter logic [7:0] IRQ_OFS     = 8'h3D,
  parameter logic [7:0] ID_VALUE    = 8'hB0,
  parameter logic [7:0] IRQ_VALUE   = 8'h04
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  output logic ddc_mode
);

  localparam int REQ_BIT   = 2;
  localparam int GRANT_BIT = 1;
  localparam logic [7:0] HANDSHAKE_RD = 8'((1 << REQ_BIT) | (1 << GRANT_BIT));

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK} st_t;

  logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
  logic scl_s, sda_s, scl_q, sda_q;
  logic scl_rise, scl_fall, start_det, stop_det;

  st_t        state;
  logic [3:0] bitcnt;
  logic [7:0] shreg, ptr, rd_value;
  logic       rw, ptr_pending, ddc_req, ddc_on, mnack;

  assign scl_s     = scl_sr[SYNC_STAGES-1];
  assign sda_s     = sda_sr[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_comb begin
    rd_value = 8'h00;
    if (ptr == SYSCTL_OFS)   rd_value = ddc_req ? HANDSHAKE_RD : 8'h00;
    else if (ptr == ID_OFS)  rd_value = ID_VALUE;
    else if (ptr == IRQ_OFS) rd_value = IRQ_VALUE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      bitcnt      <= '0;
      shreg       <= '0;
      ptr         <= '0;
      rw          <= 1'b0;
      ptr_pending <= 1'b0;
      ddc_req     <= 1'b0;
      ddc_on      <= 1'b0;
      ddc_mode    <= 1'b0;
      sda_oe      <= 1'b0;
      mnack       <= 1'b0;
    end else if (start_det) begin
      state  <= S_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state       <= S_IDLE;
      sda_oe      <= 1'b0;
      ptr_pending <= 1'b0;
      ddc_mode    <= ddc_on;
    end else begin
      case (state)
        S_ADDR: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            if (shreg[7:1] == DEV_ADDR) begin
              state       <= S_AACK;
              sda_oe      <= 1'b1;
              rw          <= shreg[0];
              ptr_pending <= ~shreg[0];
            end else begin
              state <= S_IDLE;
            end
          end
        end
        S_AACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (rw) begin
              state  <= S_RD;
              shreg  <= rd_value;
              sda_oe <= ~rd_value[7];
              ptr    <= ptr + 8'd1;
            end else begin
              state  <= S_WR;
              sda_oe <= 1'b0;
            end
          end
        end
        S_WR: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            state  <= S_WACK;
            sda_oe <= 1'b1;
            if (ptr_pending) begin
              ptr         <= shreg;
              ptr_pending <= 1'b0;
            end else begin
              if (ptr == SYSCTL_OFS) begin
                if (shreg[REQ_BIT]) begin
                  ddc_req <= 1'b1;
                  if (shreg[GRANT_BIT]) ddc_on <= 1'b1;
                end else begin
                  ddc_req <= 1'b0;
                  ddc_on  <= 1'b0;
                end
              end
              ptr <= ptr + 8'd1;
            end
          end
        end
        S_WACK: begin
          if (scl_fall) begin
            state  <= S_WR;
            sda_oe <= 1'b0;
            bitcnt <= '0;
          end
        end
        S_RD: begin
          if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              state  <= S_RACK;
              sda_oe <= 1'b0;
            end else begin
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
              bitcnt <= bitcnt + 4'd1;
            end
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            mnack <= sda_s;
          end else if (scl_fall) begin
            if (mnack) begin
              state <= S_IDLE;
            end else begin
              state  <= S_RD;
              bitcnt <= '0;
              shreg  <= rd_value;
              sda_oe <= ~rd_value[7];
              ptr    <= ptr + 8'd1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_SDA_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_oe != $past(sda_oe)) && !$past(start_det) && !$past(stop_det)) |-> !$past(scl_s)); // R12
  AST_MODE_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (ddc_mode != $past(ddc_mode)) |-> $past(stop_det)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !sda_oe); // R11
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(scl_fall && state == S_WR && bitcnt == 4'd8 && !ptr_pending && !start_det && !stop_det)
    |-> ptr == $past(ptr) + 8'd1); // R3
  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ddc_on |-> ddc_req); // R4

endmodule

// File: tb/sim_vtx_ctrl_i2c.sv
`timescale 1ns/1ps
module sim_vtx_ctrl_i2c;
  localparam int Q = 8;
  localparam logic [6:0] ADDR = 7'h39;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, ddc_mode, sda_line;
  assign sda_line = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  vtx_ctrl_i2c u0 (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
                   .sda_oe(sda_oe), .ddc_mode(ddc_mode));

  int n_chk = 0, n_bad = 0, cyc_bad = 0;
  int m_ptr = 0;
  bit m_req = 0, m_ddc = 0, m_mode = 0;
  bit cmp_en = 0, quiet = 0;

  always @(negedge clk) if (cmp_en && rst_n) begin
    if (ddc_mode !== m_mode) cyc_bad++;
    if (quiet && sda_oe) cyc_bad++;
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int mreg(int p);
    case (p)
      'h1A: return m_req ? 'h06 : 'h00;
      'h1B: return 'hB0;
      'h3D: return 'h04;
      default: return 0;
    endcase
  endfunction

  task automatic q(); repeat (Q) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1; q(); scl = 1; q(); sda_m = 0; q(); scl = 0; q();
  endtask

  task automatic i2c_stop();
    sda_m = 0; q(); scl = 1; q();
    cmp_en = 0; sda_m = 1; q();
    m_mode = m_ddc; cmp_en = 1;
  endtask

  task automatic wr_bit(bit b);
    sda_m = b; q(); scl = 1; q(); q(); scl = 0; q();
  endtask

  task automatic rd_bit(output bit b);
    sda_m = 1; q(); scl = 1; q(); b = sda_line; q(); scl = 0; q();
  endtask

  task automatic wr_byte(logic [7:0] d, output bit ack);
    bit a;
    for (int i = 7; i >= 0; i--) wr_bit(d[i]);
    rd_bit(a);
    ack = !a;
  endtask

  task automatic rd_byte(bit give_ack, output logic [7:0] d);
    bit b;
    for (int i = 7; i >= 0; i--) begin rd_bit(b); d[i] = b; end
    wr_bit(!give_ack);
  endtask

  task automatic rd_body(int n, string tag);
    bit ack; logic [7:0] d;
    wr_byte({ADDR, 1'b1}, ack);
    chk(ack, "R1 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      rd_byte(i != n - 1, d);
      chk(d == 8'(mreg(m_ptr)), tag, d, mreg(m_ptr));
      m_ptr = (m_ptr + 1) & 'hFF;
    end
  endtask

  task automatic rd_cur(int n, string tag);
    i2c_start(); rd_body(n, tag); i2c_stop();
  endtask

  task automatic rd_at(logic [7:0] p, int n, string tag);
    bit ack;
    i2c_start();
    wr_byte({ADDR, 1'b0}, ack); chk(ack, "R1 write address ack", ack, 1);
    wr_byte(p, ack); chk(ack, "R12 pointer byte ack", ack, 1);
    m_ptr = p;
    i2c_start();
    rd_body(n, tag);
    i2c_stop();
  endtask

  task automatic wr_txn(logic [7:0] p, logic [7:0] data[$], string tag, bit mode_check);
    bit ack;
    i2c_start();
    wr_byte({ADDR, 1'b0}, ack); chk(ack, "R1 write address ack", ack, 1);
    wr_byte(p, ack); chk(ack, "R2 pointer byte ack", ack, 1);
    m_ptr = p;
    foreach (data[i]) begin
      wr_byte(data[i], ack); chk(ack, {tag, " R12 data ack"}, ack, 1);
      if (m_ptr == 'h1A) begin
        if (data[i][2]) begin m_req = 1; if (data[i][1]) m_ddc = 1; end
        else begin m_req = 0; m_ddc = 0; end
      end
      m_ptr = (m_ptr + 1) & 'hFF;
    end
    if (mode_check) chk(ddc_mode == m_mode, "R9 mode held before STOP", ddc_mode, m_mode);
    i2c_stop();
    if (mode_check) chk(ddc_mode == m_ddc, "R9 mode after STOP", ddc_mode, m_ddc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    bit ack; logic [7:0] d;
    repeat (10) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(ddc_mode == 0, "R10 reset ddc_mode", ddc_mode, 0);
    chk(sda_oe == 0, "R10 reset sda released", sda_oe, 0);
    cmp_en = 1;

    m_ptr = 0;
    rd_cur(28, "R10 read from reset pointer");
    rd_at(8'h1B, 1, "R7 id register");
    rd_at(8'h3C, 3, "R8 status and neighbours");
    rd_at(8'h3C, 1, "R3 pointer setup");
    rd_cur(1, "R3 pointer kept across STOP");

    quiet = 1;
    i2c_start();
    wr_byte({7'h22, 1'b0}, ack); chk(!ack, "R1 foreign address ignored", ack, 0);
    wr_byte(8'h1A, ack); wr_byte(8'h06, ack);
    i2c_stop();
    quiet = 0;
    rd_at(8'h1A, 1, "R6 no request after foreign write");

    wr_txn(8'h1A, '{8'h04}, "R4 request only", 1);
    rd_at(8'h1A, 1, "R6 request read back");
    wr_txn(8'h1A, '{8'h06}, "R4 request and grant", 1);
    chk(ddc_mode == 1, "R4 mode on", ddc_mode, 1);
    wr_txn(8'h1A, '{8'h00}, "R5 clear", 1);
    chk(ddc_mode == 0, "R5 mode off", ddc_mode, 0);
    rd_at(8'h1A, 1, "R5 request cleared");

    wr_txn(8'h19, '{8'hAA, 8'h06, 8'h55, 8'h77}, "R3 burst", 1);
    rd_cur(1, "R3 pointer after burst");
    rd_at(8'h1A, 2, "R8 id unchanged after write");
    wr_txn(8'h3D, '{8'hFF}, "R8 status write", 0);
    rd_at(8'h3D, 1, "R8 status unchanged");
    wr_txn(8'h1A, '{8'h04}, "R4 request keeps mode", 1);
    chk(ddc_mode == 1, "R4 grant kept by request-only write", ddc_mode, 1);

    i2c_start();
    wr_byte({ADDR, 1'b0}, ack); wr_byte(8'h1B, ack); m_ptr = 'h1B;
    i2c_start();
    wr_byte({ADDR, 1'b1}, ack); chk(ack, "R1 read address ack", ack, 1);
    rd_byte(0, d);
    chk(d == 8'hB0, "R11 byte before NACK", d, 'hB0);
    repeat (2) @(negedge clk);
    chk(sda_oe == 0, "R11 released after NACK", sda_oe, 0);
    quiet = 1;
    wr_bit(1);
    chk(sda_line == 1, "R11 line stays high", sda_line, 1);
    i2c_stop();
    quiet = 0;

    chk(cyc_bad == 0, "R9 per-cycle model mismatches", cyc_bad, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule